// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block keeps one interrupt flag per message buffer in a bank of controller buffers (64 by default) and turns those flags into interrupt requests. The buffer datapath reports a finished transmit or receive on a one-cycle strobe per buffer. The flag for that buffer then latches until software writes a 1 to it. Every flag has its own mask bit. The masked flags are driven out one line per buffer and are also ORed onto a single combined line, so an interrupt handler can take one line and then read the flag words to find which buffer raised it.

When receive-FIFO mode is switched on, the lowest byte of the first flag word stops tracking buffers 0 to 7. Bits 7, 6 and 5 then report FIFO overflow, FIFO warning and frames available, and bits 4 to 0 read as zero. Five controller status events (bus-off, error, transmit warning, receive warning and wake-up) latch into a separate flag register that follows the same write-1-to-clear rules. Four of their masks sit in a control register, and the wake-up mask sits in a configuration register beside the FIFO enable. Register access uses a simple single-cycle write port and a combinational read port. Register map: 0 flag word 0, 1 flag word 1, 2 mask word 0, 3 mask word 1, 4 status flags, 5 status control, 6 configuration.

Top module: `mb_irq_flags`

## Requirements
- R1: A one-cycle strobe on `buf_done[i]` sets flag i. The flag can be read at address 0 bit i for buffers 0 to 31 and at address 1 bit i-32 for buffers 32 to 63, starting from the clock edge that samples the strobe. A strobe does not distinguish between transmit and receive.
- R2: `buf_irq[i]` is 1 only when flag i and mask bit i are both 1. The mask words are read/write at address 2 (buffers 0 to 31) and address 3 (buffers 32 to 63). `buf_irq` is registered, so it follows the flag and mask state one clock edge later.
- R3: Writing 1 to a bit of a flag word clears that flag at the write edge. Writing 0 to a bit leaves that flag unchanged.
- R4: If a set strobe for a flag arrives on the same edge as a write-1 clear of that same flag, the flag stays 1.
- R5: `mb_irq` is 1 exactly when at least one bit of `buf_irq` is 1. It is registered and updates on the same edge as `buf_irq`.
- R6: FIFO mode is bit 0 of address 6. While it is set, `fifo_evt[2]` (overflow) sets flag bit 7, `fifo_evt[1]` (warning) sets bit 6 and `fifo_evt[0]` (frames available) sets bit 5. These bits are cleared by writing 1. While FIFO mode is off, `fifo_evt` has no effect.
- R7: While FIFO mode is set, `buf_done[7:0]` has no effect. Bits 4 to 0 of address 0 read as 0 and raise no `buf_irq`, even if they were set before FIFO mode was entered.
- R8: `stat_evt` bits 0 to 4 (bus-off, error, Tx warning, Rx warning, wake-up) set status flags at address 4 bits 0 to 4. These flags are write-1-to-clear, and a set wins over a clear on the same edge.
- R9: `stat_irq[3:0]` is gated by address 5 bits 3:0. `stat_irq[4]` (wake-up) is gated by bit 1 of address 6. `stat_irq` is registered, one edge after the flags and masks.
- R10: After reset, every flag, mask, control and configuration bit is 0, and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| buf_done | input | NUM_BUF | Per-buffer completion strobes |
| fifo_evt | input | 3 | FIFO strobes: [2] overflow, [1] warning, [0] frames available |
| stat_evt | input | 5 | Status strobes: bus-off, error, Tx warn, Rx warn, wake-up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| buf_irq | output | NUM_BUF | Per-buffer masked interrupt requests |
| mb_irq | output | 1 | OR of all per-buffer requests |
| stat_irq | output | 5 | Masked status interrupt requests |

## Verification
The bench aims first at a completion strobe landing on the same edge as a software clear. A design that lets the clear win would lose an interrupt, and the flag would read 0. It writes zeros and also partial patterns to flag words that hold set flags, which catches a design that treats the write as a plain store and wipes flags it was never told to clear. It switches FIFO mode on while a low buffer flag is set, then strobes buffers 0 to 7 and the FIFO inputs. A design that remaps the bits wrongly, does not hide bits 4 to 0, or lets stray strobes through would then read the wrong value in the low byte or raise `buf_irq` bits. Finally it sets status flags with some of their masks off and checks the wake-up mask in its separate register, which exposes a mask wired to the wrong source.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  localparam int WORD_W         = 32;
  localparam int FIFO_LANES     = 8;
  localparam int FIFO_HIDE_BITS = 5;
  localparam int N_STAT         = 5;
  localparam int N_CTRL         = 4;
  localparam int N_CFG          = 2;
  localparam int CFG_FIFO       = 0;
  localparam int CFG_WAKE_MSK   = 1;
endpackage

// File: rtl/mbif_rst_sync.sv
module mbif_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_d;
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_en;

  // set has priority over a same-cycle clear
  always_comb begin
    flag_d  = set_i | (flag_q & ~clr_i);
    flag_en = set_i | clr_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[b] <= 1'b0;
      else if (flag_en[b]) flag_q[b] <= flag_d[b];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mbif_irq_gate.sv
module mbif_irq_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] msk_i,
  output logic [W-1:0] irq_o
);
  logic [W-1:0] irq_d;
  logic [W-1:0] irq_q;
  logic         irq_en;

  always_comb begin
    irq_d  = src_i & msk_i;
    irq_en = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= '0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mb_irq_flags.sv
module mb_irq_flags
  import mbif_pkg::*;
#(
  parameter  int NUM_BUF   = 64,
  localparam int NUM_WORDS = NUM_BUF / WORD_W,
  localparam int ADDR_W    = $clog2(2 * NUM_WORDS + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic [2:0]         fifo_evt,
  input  logic [N_STAT-1:0]  stat_evt,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  output logic [NUM_BUF-1:0] buf_irq,
  output logic               mb_irq,
  output logic [N_STAT-1:0]  stat_irq
);
  localparam int A_FLAG0 = 0;
  localparam int A_MASK0 = NUM_WORDS;
  localparam int A_STAT  = 2 * NUM_WORDS;
  localparam int A_CTRL  = A_STAT + 1;
  localparam int A_CFG   = A_STAT + 2;
  localparam logic [NUM_BUF-1:0] HIDE_VEC =
    {{(NUM_BUF-FIFO_HIDE_BITS){1'b0}}, {FIFO_HIDE_BITS{1'b1}}};

  logic                 rst_q_n;
  logic [NUM_BUF-1:0]   buf_set, buf_clr, flag_q, flag_vis, mask_q;
  logic [NUM_WORDS-1:0] mask_we;
  logic [N_STAT-1:0]    stat_clr, stat_q, stat_msk;
  logic [N_CTRL-1:0]    ctrl_q, ctrl_d;
  logic [N_CFG-1:0]     cfg_q, cfg_d;
  logic                 ctrl_we, cfg_we, fifo_en;
  logic                 any_d, any_q, any_en;

  mbif_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign fifo_en = cfg_q[CFG_FIFO];

  // set sources: FIFO mode reroutes the low byte to FIFO events
  always_comb begin
    buf_set = buf_done;
    if (fifo_en)
      buf_set[FIFO_LANES-1:0] = {fifo_evt, {FIFO_HIDE_BITS{1'b0}}};
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign buf_clr[w*WORD_W +: WORD_W] =
      (wr_en && int'(wr_addr) == A_FLAG0 + w) ? wr_data : '0;
    assign mask_we[w] = wr_en && int'(wr_addr) == A_MASK0 + w;

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)        mask_q[w*WORD_W +: WORD_W] <= '0;
      else if (mask_we[w]) mask_q[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  mbif_flag_bank #(.W(NUM_BUF)) u_buf_flags (
    .clk(clk), .rst_n(rst_q_n), .set_i(buf_set), .clr_i(buf_clr), .flag_o(flag_q)
  );

  assign flag_vis = fifo_en ? (flag_q & ~HIDE_VEC) : flag_q;

  mbif_irq_gate #(.W(NUM_BUF)) u_buf_gate (
    .clk(clk), .rst_n(rst_q_n), .src_i(flag_vis), .msk_i(mask_q), .irq_o(buf_irq)
  );

  // combined line
  always_comb begin
    any_d  = |(flag_vis & mask_q);
    any_en = (any_d != any_q);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    any_q <= 1'b0;
    else if (any_en) any_q <= any_d;
  end

  assign mb_irq = any_q;

  // status sources
  assign stat_clr = (wr_en && int'(wr_addr) == A_STAT) ? wr_data[N_STAT-1:0] : '0;

  mbif_flag_bank #(.W(N_STAT)) u_stat_flags (
    .clk(clk), .rst_n(rst_q_n), .set_i(stat_evt), .clr_i(stat_clr), .flag_o(stat_q)
  );

  always_comb begin
    ctrl_we = wr_en && int'(wr_addr) == A_CTRL;
    cfg_we  = wr_en && int'(wr_addr) == A_CFG;
    ctrl_d  = wr_data[N_CTRL-1:0];
    cfg_d   = wr_data[N_CFG-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign stat_msk = {cfg_q[CFG_WAKE_MSK], ctrl_q};

  mbif_irq_gate #(.W(N_STAT)) u_stat_gate (
    .clk(clk), .rst_n(rst_q_n), .src_i(stat_q), .msk_i(stat_msk), .irq_o(stat_irq)
  );

  // read port
  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (int'(rd_addr) == A_FLAG0 + w) rd_data = flag_vis[w*WORD_W +: WORD_W];
      if (int'(rd_addr) == A_MASK0 + w) rd_data = mask_q[w*WORD_W +: WORD_W];
    end
    if (int'(rd_addr) == A_STAT) rd_data[N_STAT-1:0] = stat_q;
    if (int'(rd_addr) == A_CTRL) rd_data[N_CTRL-1:0] = ctrl_q;
    if (int'(rd_addr) == A_CFG)  rd_data[N_CFG-1:0]  = cfg_q;
  end
endmodule

// File: rtl/mb_irq_flags_chk.sv
module mb_irq_flags_chk #(
  parameter int NUM_BUF = 64,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [NUM_BUF-1:0] buf_done,
  input logic [2:0]         fifo_evt,
  input logic [4:0]         stat_evt,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [31:0]        wr_data,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [31:0]        rd_data,
  input logic [NUM_BUF-1:0] buf_irq,
  input logic               mb_irq,
  input logic [4:0]         stat_irq,
  input logic [NUM_BUF-1:0] flag_q,
  input logic [NUM_BUF-1:0] mask_q,
  input logic [4:0]         stat_q,
  input logic [4:0]         stat_msk,
  input logic               fifo_en
);
  // R1, R4: a strobe on a buffer above the FIFO byte always leaves its flag set
  p_set_sticks_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|buf_done[NUM_BUF-1:8]) |=>
      ((flag_q[NUM_BUF-1:8] & $past(buf_done[NUM_BUF-1:8])) == $past(buf_done[NUM_BUF-1:8])));

  p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((buf_irq & ~$past(mask_q)) == '0));

  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_addr == '0 && wr_data[31] && !buf_done[31]) |=> !flag_q[31]);

  p_w0_hold_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_addr == '0 && wr_data == '0 && buf_done[31:0] == '0 && fifo_evt == '0)
      |=> $stable(flag_q[31:0]));

  p_any_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    mb_irq == (buf_irq != '0));

  p_fifo_hide_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fifo_en && rd_addr == '0) |-> (rd_data[4:0] == 5'd0));

  p_fifo_noset_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fifo_en && flag_q[4:0] == 5'd0) |=> (flag_q[4:0] == 5'd0));

  p_stat_set_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|stat_evt) |=> ((stat_q & $past(stat_evt)) == $past(stat_evt)));

  p_stat_masked_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((stat_irq & ~$past(stat_msk)) == 5'd0));
endmodule

bind mb_irq_flags mb_irq_flags_chk #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .buf_done(buf_done), .fifo_evt(fifo_evt),
  .stat_evt(stat_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .buf_irq(buf_irq), .mb_irq(mb_irq),
  .stat_irq(stat_irq), .flag_q(flag_q), .mask_q(mask_q), .stat_q(stat_q),
  .stat_msk(stat_msk), .fifo_en(fifo_en)
);

// File: tb/mb_irq_flags_test.sv
module mb_irq_flags_test;
  localparam int A_FLAG0 = 0, A_FLAG1 = 1, A_MASK0 = 2, A_MASK1 = 3;
  localparam int A_STAT = 4, A_CTRL = 5, A_CFG = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] buf_done;
  logic [2:0]  fifo_evt;
  logic [4:0]  stat_evt;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [63:0] buf_irq;
  logic        mb_irq;
  logic [4:0]  stat_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mb_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .buf_done(buf_done), .fifo_evt(fifo_evt),
    .stat_evt(stat_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .buf_irq(buf_irq), .mb_irq(mb_irq),
    .stat_irq(stat_irq)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = a[2:0];
    #1;
    d = rd_data;
  endtask

  task automatic pulse_buf(input logic [63:0] v);
    buf_done = v;
    tick();
    buf_done = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(a, d);
      check("R10", $sformatf("reg %0d after reset", a), {32'd0, d}, 64'd0);
    end
    check("R10", "buf_irq after reset", buf_irq, 64'd0);
    check("R10", "irq lines after reset", {58'd0, mb_irq, stat_irq}, 64'd0);
  endtask

  task automatic t_set_and_mask();
    logic [31:0] d;
    pulse_buf((64'd1 << 3) | (64'd1 << 40));
    rd(A_FLAG0, d); check("R1", "word0 after strobe 3", {32'd0, d}, 64'h8);
    rd(A_FLAG1, d); check("R1", "word1 after strobe 40", {32'd0, d}, 64'h100);
    tick();
    check("R2", "unmasked flags give no irq", buf_irq, 64'd0);
    check("R5", "combined idle when unmasked", {63'd0, mb_irq}, 64'd0);
    wr(A_MASK0, 32'h0000_0008);
    rd(A_MASK0, d); check("R2", "mask word0 readback", {32'd0, d}, 64'h8);
    tick();
    check("R2", "buf_irq bit 3 with mask", buf_irq, 64'h8);
    check("R5", "combined raised", {63'd0, mb_irq}, 64'd1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_FLAG0, 32'h0);
    rd(A_FLAG0, d); check("R3", "write 0 keeps flag", {32'd0, d}, 64'h8);
    wr(A_FLAG0, 32'hFFFF_FFF7);
    rd(A_FLAG0, d); check("R3", "write 1 to other bits keeps flag", {32'd0, d}, 64'h8);
    wr(A_FLAG0, 32'h8);
    rd(A_FLAG0, d); check("R3", "write 1 clears flag", {32'd0, d}, 64'h0);
    tick();
    check("R5", "combined drops after clear", {63'd0, mb_irq}, 64'd0);
    wr(A_MASK0, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    buf_done = 64'd1 << 40;
    wr(A_FLAG1, 32'h100);
    buf_done = '0;
    rd(A_FLAG1, d); check("R4", "set beats same-edge clear", {32'd0, d}, 64'h100);
    wr(A_FLAG1, 32'h100);
    rd(A_FLAG1, d); check("R3", "later clear works", {32'd0, d}, 64'h0);
  endtask

  task automatic t_high_buffer();
    logic [31:0] d;
    wr(A_MASK1, 32'h8000_0000);
    rd(A_MASK1, d); check("R2", "mask word1 readback", {32'd0, d}, 64'h8000_0000);
    pulse_buf(64'd1 << 63);
    tick();
    check("R2", "buf_irq bit 63", buf_irq, 64'd1 << 63);
    check("R5", "combined from buffer 63", {63'd0, mb_irq}, 64'd1);
    wr(A_FLAG1, 32'h8000_0000);
    wr(A_MASK1, 32'h0);
    tick();
    check("R5", "combined idle again", {63'd0, mb_irq}, 64'd0);
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    fifo_evt = 3'b111; tick(); fifo_evt = '0;
    rd(A_FLAG0, d); check("R6", "fifo events ignored outside mode", {32'd0, d}, 64'h0);
    pulse_buf(64'h4);
    wr(A_MASK0, 32'hFF);
    tick();
    check("R2", "buf 2 irq before fifo mode", buf_irq, 64'h4);
    wr(A_CFG, 32'h1);
    rd(A_FLAG0, d); check("R7", "bits 4..0 hidden in fifo mode", {32'd0, d}, 64'h0);
    tick();
    check("R7", "hidden bit raises no irq", buf_irq, 64'h0);
    pulse_buf(64'hFF);
    rd(A_FLAG0, d); check("R7", "buffer strobes 0..7 ignored", {32'd0, d}, 64'h0);
    fifo_evt = 3'b101; tick(); fifo_evt = '0;
    rd(A_FLAG0, d); check("R6", "overflow and frames-available", {32'd0, d}, 64'hA0);
    fifo_evt = 3'b010; tick(); fifo_evt = '0;
    rd(A_FLAG0, d); check("R6", "warning added", {32'd0, d}, 64'hE0);
    wr(A_FLAG0, 32'h80);
    rd(A_FLAG0, d); check("R6", "overflow cleared by write 1", {32'd0, d}, 64'h60);
    tick();
    check("R6", "fifo flags drive irq", buf_irq, 64'h60);
    wr(A_CFG, 32'h0);
    rd(A_FLAG0, d); check("R7", "buf 2 flag back after leaving fifo mode", {32'd0, d}, 64'h64);
    wr(A_FLAG0, 32'hFF);
    wr(A_MASK0, 32'h0);
    tick();
    check("R10", "all buffer irq clear", buf_irq, 64'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    stat_evt = 5'h1F; tick(); stat_evt = '0;
    rd(A_STAT, d); check("R8", "all status flags latched", {32'd0, d}, 64'h1F);
    tick();
    check("R9", "status masked off", {59'd0, stat_irq}, 64'h0);
    wr(A_CTRL, 32'h5);
    rd(A_CTRL, d); check("R9", "control readback", {32'd0, d}, 64'h5);
    tick();
    check("R9", "bus-off and Tx warn irq", {59'd0, stat_irq}, 64'h05);
    wr(A_CFG, 32'h2);
    tick();
    check("R9", "wake mask in config", {59'd0, stat_irq}, 64'h15);
    stat_evt = 5'h01;
    wr(A_STAT, 32'h01);
    stat_evt = '0;
    rd(A_STAT, d); check("R8", "status set beats clear", {32'd0, d}, 64'h1F);
    wr(A_STAT, 32'h0A);
    rd(A_STAT, d); check("R8", "partial status clear", {32'd0, d}, 64'h15);
    wr(A_STAT, 32'h1F);
    tick();
    check("R9", "status irq drops", {59'd0, stat_irq}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; buf_done = '0; fifo_evt = '0; stat_evt = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_set_and_mask();
    t_w1c();
    t_collide();
    t_high_buffer();
    t_fifo();
    t_status();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule